// File: doc/BRIEF.md
# Interrupt Request Combiner

This block collects interrupt requests from several parallel port devices and from two interval counters and merges them into one registered interrupt line for the host. Each device has two ports, and every port request has its own enable bit. Only one counter at a time can act as the timer source. A falling edge on the chosen counter output sets a sticky pending flag. That flag stays set until the host writes to a clear address.

The host reaches the block through a small 8-bit register interface. Two control registers are write-only: one holds the per-port enables, the other holds the master enable, the counter enable and the counter select. A third address takes a clear write. Reads return the raw request state, so software can see which source is asking for service. The port devices and the counters are outside this block and appear only as input signals.

Top module: `irq_combiner`

## Requirements
- R1: After reset the port enables, the control bits and the timer pending flag are all zero, `hostIrq` is low, and a read of address 1 returns 0x00.
- R2: A write to address 0 loads the port enable mask. Request bit `2*d+p` (device d, port p, with port A as p=0) is passed on only when mask bit `2*d+p` is set. Bit 0 is device 0 port A and bit 5 is device 2 port B. A request whose mask bit is clear never raises `hostIrq`.
- R3: A write to address 1 loads the control byte, and bit 2 of that byte is the master enable. While the master enable is clear, `hostIrq` stays low whatever the sources hold. Writing 0x00 to address 1 therefore silences the block.
- R4: Control bit 1 is the counter enable. While it is clear, a counter edge does not set the pending flag, and a flag that is already pending does not drive `hostIrq`.
- R5: Control bit 0 selects the timer source. With bit 0 = 1, `ctrOut[1]` is the source; with bit 0 = 0, `ctrOut[0]` is the source. Edges on the unselected counter are ignored.
- R6: A high-to-low change of the selected counter output, seen between two clock edges while the counter is enabled, sets the pending flag. The flag stays set after the counter output goes high again.
- R7: A write of any data to address 2 clears the pending flag. If a new falling edge arrives in the same cycle, the flag stays set.
- R8: A read of address 0 returns the raw `portReq` bits, whatever the mask holds. A read of address 1 returns the pending flag in bit 0 and zeros above it. Reads of addresses 2 and 3 return 0x00.
- R9: `hostIrq` is registered: it changes on the clock edge after the state or request change that causes it.
- R10: `hostIrq` is the master enable ANDed with the OR of all unmasked port requests and the counter-enabled pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for busAddr, combinational |
| portReq | input | 8 | Raw port requests, bit 2*d+p |
| ctrOut | input | 2 | Counter outputs, bit 0 = counter 0 |
| hostIrq | output | 1 | Combined interrupt request to the host |

## Verification
The bench targets the single-bit boundaries of the mask (bit 0 and bit 5), a counter falling edge on the unselected input, and a clear write that lands in the same cycle as a new edge. A design that let the clear win would lose that edge. A design that decoded the select backwards would raise an interrupt from the wrong counter. The bench also checks that a pending flag survives the counter rising again. It checks that turning off the counter enable masks a flag that is already pending without erasing it. Finally it checks that the interrupt output lags its cause by exactly one cycle, which a combinational output would not.

// File: rtl/irq_combiner_pkg.sv
package irq_combiner_pkg;
  localparam int unsigned REG_W = 8;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_PORT_EN = 2'd0,
    ADDR_CTRL    = 2'd1,
    ADDR_CLEAR   = 2'd2,
    ADDR_SPARE   = 2'd3
  } regAddr_e;

  // control byte field positions
  localparam int unsigned CTRL_SEL_BIT    = 0;
  localparam int unsigned CTRL_CTR_EN_BIT = 1;
  localparam int unsigned CTRL_MASTER_BIT = 2;

  typedef struct packed {
    logic wrPortEn;
    logic wrCtrl;
    logic clrTimer;
  } strobes_t;
endpackage

// File: rtl/irq_combiner_ctrl.sv
module irq_combiner_ctrl
  import irq_combiner_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NUM_SRC-1:0] portReq,
  input  logic              timerPendingQ,
  output strobes_t          strobes,
  output logic [REG_W-1:0]  busRdData
);
  regAddr_e addr;
  assign addr = regAddr_e'(busAddr);

  always_comb begin
    strobes = '0;
    if (busWrEn) begin
      unique case (addr)
        ADDR_PORT_EN: strobes.wrPortEn = 1'b1;
        ADDR_CTRL:    strobes.wrCtrl   = 1'b1;
        ADDR_CLEAR:   strobes.clrTimer = 1'b1;
        default:      strobes = '0;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_PORT_EN: busRdData = REG_W'(portReq);
      ADDR_CTRL:    busRdData = REG_W'(timerPendingQ);
      default:      busRdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_combiner_dp.sv
module irq_combiner_dp
  import irq_combiner_pkg::*;
#(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strobes,
  input  logic [REG_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0] portReq,
  input  logic [1:0]         ctrOut,
  output logic [NUM_SRC-1:0] portEnQ,
  output logic               ctrSelQ,
  output logic               ctrEnQ,
  output logic               masterEnQ,
  output logic               timerPendingQ,
  output logic               hostIrq
);
  logic [1:0]         ctrPrevQ;
  logic [NUM_SRC-1:0] gatedReq;
  logic               timerFall;
  logic               irqNext;
  logic               unusedWrBits;

  assign unusedWrBits = ^wrData;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
    assign gatedReq[g] = portReq[g] & portEnQ[g];
  end

  assign timerFall = ctrEnQ & ctrPrevQ[ctrSelQ] & ~ctrOut[ctrSelQ];
  assign irqNext   = masterEnQ & ((|gatedReq) | (timerPendingQ & ctrEnQ));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      portEnQ       <= '0;
      ctrSelQ       <= 1'b0;
      ctrEnQ        <= 1'b0;
      masterEnQ     <= 1'b0;
      timerPendingQ <= 1'b0;
      ctrPrevQ      <= '0;
      hostIrq       <= 1'b0;
    end else begin
      if (strobes.wrPortEn) portEnQ <= wrData[NUM_SRC-1:0];
      if (strobes.wrCtrl) begin
        ctrSelQ   <= wrData[CTRL_SEL_BIT];
        ctrEnQ    <= wrData[CTRL_CTR_EN_BIT];
        masterEnQ <= wrData[CTRL_MASTER_BIT];
      end
      ctrPrevQ <= ctrOut;
      if (timerFall)             timerPendingQ <= 1'b1;
      else if (strobes.clrTimer) timerPendingQ <= 1'b0;
      hostIrq <= irqNext;
    end
  end
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner
  import irq_combiner_pkg::*;
#(
  parameter int unsigned NUM_DEV       = 4,
  parameter int unsigned PORTS_PER_DEV = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               busWrEn,
  input  logic [1:0]                         busAddr,
  input  logic [7:0]                         busWrData,
  output logic [7:0]                         busRdData,
  input  logic [NUM_DEV*PORTS_PER_DEV-1:0]   portReq,
  input  logic [1:0]                         ctrOut,
  output logic                               hostIrq
);
  localparam int unsigned NUM_SRC = NUM_DEV * PORTS_PER_DEV;

  strobes_t           strobes;
  logic [NUM_SRC-1:0] portEnQ;
  logic               ctrSelQ;
  logic               ctrEnQ;
  logic               masterEnQ;
  logic               timerPendingQ;

  irq_combiner_ctrl #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .busWrEn       (busWrEn),
    .busAddr       (busAddr),
    .portReq       (portReq),
    .timerPendingQ (timerPendingQ),
    .strobes       (strobes),
    .busRdData     (busRdData)
  );

  irq_combiner_dp #(.NUM_SRC(NUM_SRC)) i_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .wrData        (busWrData),
    .portReq       (portReq),
    .ctrOut        (ctrOut),
    .portEnQ       (portEnQ),
    .ctrSelQ       (ctrSelQ),
    .ctrEnQ        (ctrEnQ),
    .masterEnQ     (masterEnQ),
    .timerPendingQ (timerPendingQ),
    .hostIrq       (hostIrq)
  );
endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int unsigned NUM_SRC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               busWrEn,
  input logic [1:0]         busAddr,
  input logic [7:0]         busRdData,
  input logic [1:0]         ctrOut,
  input logic [NUM_SRC-1:0] portEnQ,
  input logic               ctrEnQ,
  input logic               masterEnQ,
  input logic               timerPendingQ,
  input logic               hostIrq
);
  logic clearWr;
  assign clearWr = busWrEn && (busAddr == 2'd2);

  a_r3_master_off: assert property (@(posedge clk) disable iff (!rstN)
    !masterEnQ |=> !hostIrq);

  a_r2_all_masked: assert property (@(posedge clk) disable iff (!rstN)
    (portEnQ == '0 && !ctrEnQ) |=> !hostIrq);

  a_r4_no_set_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrEnQ && !timerPendingQ) |=> !timerPendingQ);

  a_r6_pending_holds: assert property (@(posedge clk) disable iff (!rstN)
    (timerPendingQ && !clearWr) |=> timerPendingQ);

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rstN)
    (clearWr && $stable(ctrOut)) |=> !timerPendingQ);

  a_r8_status_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd1) |-> (busRdData[7:1] == 7'd0));
endmodule

bind irq_combiner irq_combiner_chk #(.NUM_SRC(NUM_SRC)) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .busWrEn       (busWrEn),
  .busAddr       (busAddr),
  .busRdData     (busRdData),
  .ctrOut        (ctrOut),
  .portEnQ       (portEnQ),
  .ctrEnQ        (ctrEnQ),
  .masterEnQ     (masterEnQ),
  .timerPendingQ (timerPendingQ),
  .hostIrq       (hostIrq)
);

// File: tb/test_irq_combiner.sv
`timescale 1ns/1ps
module test_irq_combiner;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic [7:0] portReq = 8'h00;
  logic [1:0] ctrOut = 2'b11;
  logic       hostIrq;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  irq_combiner i_irq_combiner (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .portReq(portReq),
    .ctrOut(ctrOut), .hostIrq(hostIrq)
  );

  // {portEn, ctrl, portReq, expected hostIrq}
  localparam logic [24:0] VEC [8] = '{
    {8'h01, 8'h04, 8'h01, 1'b1},  // R2 bit 0
    {8'h20, 8'h04, 8'h20, 1'b1},  // R2 bit 5
    {8'h20, 8'h04, 8'h10, 1'b0},  // R2 neighbour masked
    {8'hFF, 8'h00, 8'hFF, 1'b0},  // R3 master off
    {8'h00, 8'h04, 8'hFF, 1'b0},  // R2 all masked
    {8'h80, 8'h04, 8'h81, 1'b1},  // R10 top bit
    {8'h7E, 8'h06, 8'h81, 1'b0},  // R10 nothing pending
    {8'hFF, 8'h04, 8'h00, 1'b0}   // R10 no requests
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    step(3);
    rstN = 1'b1;
    step(1);

    // R1 reset state
    chk("R1 hostIrq", {7'd0, hostIrq}, 8'h00);
    busRead(2'd1, rd); chk("R1 pending status", rd, 8'h00);
    portReq = 8'h5A; step(2);
    chk("R1 masks clear", {7'd0, hostIrq}, 8'h00);

    // vector table
    for (int i = 0; i < 8; i++) begin
      busWrite(2'd0, VEC[i][24:17]);
      busWrite(2'd1, VEC[i][16:9]);
      @(negedge clk); portReq = VEC[i][8:1];
      @(negedge clk);
      chk($sformatf("R2/R3/R10 vec%0d", i), {7'd0, hostIrq}, {7'd0, VEC[i][0]});
      busRead(2'd0, rd); chk($sformatf("R8 raw vec%0d", i), rd, VEC[i][8:1]);
    end
    busRead(2'd2, rd); chk("R8 addr2 zero", rd, 8'h00);
    busRead(2'd3, rd); chk("R8 addr3 zero", rd, 8'h00);

    portReq = 8'h00;
    busWrite(2'd0, 8'h00);

    // R4 counter disabled: edge ignored
    busWrite(2'd1, 8'h04);
    ctrOut = 2'b11; step(2);
    ctrOut = 2'b00; step(2);
    busRead(2'd1, rd); chk("R4 no latch when off", rd, 8'h00);
    chk("R4 no irq when off", {7'd0, hostIrq}, 8'h00);

    // R5 select counter 0, counter 1 edge ignored
    ctrOut = 2'b11;
    busWrite(2'd1, 8'h06);
    step(1);
    ctrOut = 2'b01; step(2);
    busRead(2'd1, rd); chk("R5 unselected ignored", rd, 8'h00);
    ctrOut = 2'b00; step(1);
    busRead(2'd1, rd); chk("R6 latch on fall", rd, 8'h01);
    chk("R9 one cycle lag", {7'd0, hostIrq}, 8'h00);
    step(1);
    chk("R10 timer irq", {7'd0, hostIrq}, 8'h01);
    ctrOut = 2'b11; step(3);
    busRead(2'd1, rd); chk("R6 holds after rise", rd, 8'h01);
    chk("R6 irq holds", {7'd0, hostIrq}, 8'h01);

    // R4 disabling counter masks pending flag but keeps it
    busWrite(2'd1, 8'h04); step(1);
    chk("R4 pending masked", {7'd0, hostIrq}, 8'h00);
    busRead(2'd1, rd); chk("R4 pending kept", rd, 8'h01);

    // R3 master off with pending flag
    busWrite(2'd1, 8'h02); step(1);
    chk("R3 master off pending", {7'd0, hostIrq}, 8'h00);
    busWrite(2'd1, 8'h06); step(1);
    chk("R3 master back on", {7'd0, hostIrq}, 8'h01);

    // R7 clear with arbitrary data
    busWrite(2'd2, 8'hA5);
    busRead(2'd1, rd); chk("R7 clear", rd, 8'h00);
    step(1);
    chk("R7 irq drops", {7'd0, hostIrq}, 8'h00);

    // R5 select counter 1
    busWrite(2'd1, 8'h07);
    step(1);
    ctrOut = 2'b10; step(2);
    busRead(2'd1, rd); chk("R5 ctr0 ignored when sel1", rd, 8'h00);
    ctrOut = 2'b00; step(1);
    busRead(2'd1, rd); chk("R5 ctr1 selected", rd, 8'h01);
    busWrite(2'd2, 8'h00);
    busRead(2'd1, rd); chk("R7 clear zero data", rd, 8'h00);

    // R7 clear and new edge in the same cycle: set wins
    ctrOut = 2'b11; step(2);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 2'd2; busWrData = 8'hFF; ctrOut = 2'b01;
    @(negedge clk);
    busWrEn = 1'b0;
    busRead(2'd1, rd); chk("R7 edge beats clear", rd, 8'h01);

    // R3 writing zero silences everything
    portReq = 8'hFF;
    busWrite(2'd0, 8'hFF);
    busWrite(2'd1, 8'h00);
    step(2);
    chk("R3 zero control", {7'd0, hostIrq}, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule